// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Identification Word

This block is a serial test access port that sits between four test pins (test clock, mode select, serial in, serial out) and the device's pads. A 16-state controller, stepped by the mode-select line on rising test-clock edges, sequences capture, shift and update of an 8-bit instruction register and of one of three data registers. The three data registers are a fixed 32-bit identification word, a single bypass bit, and a 216-cell boundary chain that spans every pad.

The boundary chain is built from 72 groups of three cells. The lowest cell of a group is the output-enable cell, the middle cell is the drive cell and the highest cell is the sampled-input cell. Groups above the last pad are filler cells with no pad behind them. Two instructions drive the pads differently. With the external-test instruction, each pad is driven from the update latches of its group. With every other instruction, the core's own drive and enable values pass straight through. The sample/preload instruction snapshots the pads into the chain and leaves them undisturbed.

All pins are plain level signals. No valid/ready handshake applies, because the serial protocol paces itself on the test clock and has no back-pressure. An active-low power-on reset, `por_n`, puts the controller into its reset state in the same way as five mode-select-high clocks.

Top module: `boundary_tap`

## Requirements
- R1: After `por_n` or Test-Logic-Reset, the instruction is the identification opcode 0x01, and a 32-bit data scan returns 0x29504093, least significant bit first. That word is built from a 4-bit version 0010, a 16-bit part field 1001010100000100, an 11-bit maker field 00001001001 and a trailing 1.
- R2: Five consecutive rising test-clock edges with mode-select high reach Test-Logic-Reset from any state.
- R3: The instruction register is 8 bits long and loads 0x01 on Capture-IR, so an IR scan returns 1,0,0,0,0,0,0,0 in that order. The opcodes are 0x00 external test, 0x01 identification, 0x02 sample/preload and 0xFF bypass.
- R4: Bypass (0xFF) and every opcode not listed in R3 select a 1-bit data register that captures 0.
- R5: Under 0x00 or 0x02, exactly 216 cells lie between serial in and serial out. Serial in enters cell 215, and cell 0 leaves first.
- R6: On Capture-DR under 0x02, pad group p (p < 34) loads cell 3p with the pad enable, cell 3p+1 with the pad drive value and cell 3p+2 with `pin_in[p]`. Filler groups 34..71 load 0.
- R7: Under 0x00, `pad_out[p]` equals the drive latch of group p and `pad_oe[p]` equals its enable latch. The cells are written highest index first: 1-1-1 drives a 1, 1-0-1 drives a 0, and 1-0-0 releases the pad.
- R8: The update latches change only on Update-DR with 0x00 or 0x02 active, or on Test-Logic-Reset, which clears them. Running external test straight after a reset therefore releases every pad.
- R9: `tdo` changes on falling test-clock edges only. `tdo_en` is high only while a register is being shifted.
- R10: Under any instruction other than 0x00, `pad_out` and `pad_oe` follow `core_out` and `core_oe`, including during boundary scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Active-low power-on reset |
| tms | input | 1 | Mode select, sampled on rising edges |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdo_en | output | 1 | High while serial out carries shifted data |
| core_out | input | 34 | Core drive value per pad |
| core_oe | input | 34 | Core output enable per pad |
| pin_in | input | 34 | Value observed at each pad |
| pad_out | output | 34 | Drive value sent to each pad |
| pad_oe | output | 34 | Output enable sent to each pad (0 releases) |

## Verification
Sample/preload scans are run with random core drive, core enable and pad-input vectors. This separates the three cells of each group and shows that the filler groups stay at zero. Random preload patterns are followed by a switch to external test, and the pad comparison shows whether the latches and the pad multiplexer carry the right cell of each group. Directed patterns cover the three group codes, bypass under random unassigned opcodes, a single marker bit that measures the chain at exactly 216 cells, and a reset issued in the middle of a shift. A bypass-mode scan placed between two external-test phases shows that the latches ignore scans made under other instructions.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    DR_BYPASS, DR_IDENT, DR_CHAIN
  } dr_sel_e;

  localparam logic [IR_W-1:0] OPC_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] OPC_IDENT  = 8'h01;
  localparam logic [IR_W-1:0] OPC_SAMPLE = 8'h02;
  localparam logic [IR_W-1:0] OPC_BYPASS = 8'hFF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_RESET;
    else        state <= nxt;
  end

  // Checker-side count of consecutive mode-select-high edges
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                ones_q <= '0;
    else if (!tms)             ones_q <= '0;
    else if (ones_q != 3'd5)   ones_q <= ones_q + 3'd1;
  end

  // R2
  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
    (ones_q == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_so,
  output dr_sel_e    dr_sel,
  output logic       extest
);

  logic [IR_W-1:0] shreg;
  logic [IR_W-1:0] instr;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      shreg <= IR_CAPTURE;
    end else if (state == ST_CAP_IR) begin
      shreg <= IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      shreg <= {tdi, shreg[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                  instr <= OPC_IDENT;
    else if (state == ST_RESET)  instr <= OPC_IDENT;
    else if (state == ST_UPD_IR) instr <= shreg;
  end

  always_comb begin
    extest = 1'b0;
    unique case (instr)
      OPC_EXTEST: begin dr_sel = DR_CHAIN; extest = 1'b1; end
      OPC_SAMPLE: dr_sel = DR_CHAIN;
      OPC_IDENT:  dr_sel = DR_IDENT;
      default:    dr_sel = DR_BYPASS;
    endcase
  end

  assign ir_so = shreg[0];

  // R1
  a_r1_reset_selects_ident: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_RESET) |=> (dr_sel == DR_IDENT && !extest));

  // R3
  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_CAP_IR) |=> (ir_so == 1'b1));

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_PINS   = 34,
  parameter int NUM_GROUPS = 72
) (
  input  logic                tck,
  input  logic                por_n,
  input  logic                tdi,
  input  tap_state_e          state,
  input  logic                sel_chain,
  input  logic                extest,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                chain_so
);

  localparam int CHAIN_LEN = 3 * NUM_GROUPS;

  logic [CHAIN_LEN-1:0] cells;
  logic [CHAIN_LEN-1:0] cap;
  logic [NUM_PINS-1:0]  lat_out, lat_oe;
  logic [NUM_PINS-1:0]  lat_out_d, lat_oe_d;

  // Pad multiplexer: scan latches only under external test
  assign pad_out = extest ? lat_out : core_out;
  assign pad_oe  = extest ? lat_oe  : core_oe;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    if (g < NUM_PINS) begin : g_pad
      assign cap[3*g]   = pad_oe[g];
      assign cap[3*g+1] = pad_out[g];
      assign cap[3*g+2] = pin_in[g];
      assign lat_oe_d[g]  = cells[3*g];
      assign lat_out_d[g] = cells[3*g+1];
    end else begin : g_fill
      assign cap[3*g+2 -: 3] = 3'b000;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      cells <= '0;
    end else if (sel_chain) begin
      if (state == ST_CAP_DR)     cells <= cap;
      else if (state == ST_SH_DR) cells <= {tdi, cells[CHAIN_LEN-1:1]};
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      lat_out <= '0;
      lat_oe  <= '0;
    end else if (state == ST_RESET) begin
      lat_out <= '0;
      lat_oe  <= '0;
    end else if (state == ST_UPD_DR && sel_chain) begin
      lat_out <= lat_out_d;
      lat_oe  <= lat_oe_d;
    end
  end

  assign chain_so = cells[0];

  // R8
  a_r8_latch_only_on_update: assert property (@(posedge tck) disable iff (!por_n)
    !$stable({lat_out, lat_oe}) |->
      (($past(state) == ST_UPD_DR && $past(sel_chain)) || $past(state) == ST_RESET));

  // R8
  a_r8_reset_clears_enables: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_RESET) |=> (lat_oe == '0));

endmodule

// File: rtl/boundary_tap.sv
module boundary_tap
  import bscan_pkg::*;
#(
  parameter int          NUM_PINS   = 34,
  parameter int          NUM_GROUPS = 72,
  parameter logic [31:0] ID_WORD    = {4'b0010, 16'b1001010100000100, 11'b00001001001, 1'b1}
) (
  input  logic                tck,
  input  logic                por_n,
  input  logic                tms,
  input  logic                tdi,
  output logic                tdo,
  output logic                tdo_en,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  tap_state_e state;
  dr_sel_e    dr_sel;
  logic       extest, ir_so, chain_so;
  logic [31:0] id_sr;
  logic        byp;
  logic        dr_so;

  tap_ctrl u_ctrl (.tck(tck), .por_n(por_n), .tms(tms), .state(state));

  tap_ir u_ir (
    .tck(tck), .por_n(por_n), .tdi(tdi), .state(state),
    .ir_so(ir_so), .dr_sel(dr_sel), .extest(extest)
  );

  bscan_chain #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_chain (
    .tck(tck), .por_n(por_n), .tdi(tdi), .state(state),
    .sel_chain(dr_sel == DR_CHAIN), .extest(extest),
    .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .chain_so(chain_so)
  );

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      id_sr <= ID_WORD;
      byp   <= 1'b0;
    end else begin
      if (dr_sel == DR_IDENT) begin
        if (state == ST_CAP_DR)     id_sr <= ID_WORD;
        else if (state == ST_SH_DR) id_sr <= {tdi, id_sr[31:1]};
      end
      if (dr_sel == DR_BYPASS) begin
        if (state == ST_CAP_DR)     byp <= 1'b0;
        else if (state == ST_SH_DR) byp <= tdi;
      end
    end
  end

  always_comb begin
    unique case (dr_sel)
      DR_IDENT: dr_so = id_sr[0];
      DR_CHAIN: dr_so = chain_so;
      default:  dr_so = byp;
    endcase
  end

  // Serial out retimed to the falling edge
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else if (state == ST_SH_IR) begin
      tdo    <= ir_so;
      tdo_en <= 1'b1;
    end else if (state == ST_SH_DR) begin
      tdo    <= dr_so;
      tdo_en <= 1'b1;
    end else begin
      tdo_en <= 1'b0;
    end
  end

  // R9
  a_r9_enable_only_shifting: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));

  // R4
  a_r4_bypass_captures_zero: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_CAP_DR && dr_sel == DR_BYPASS) |=> (byp == 1'b0));

endmodule

// File: tb/test_boundary_tap.sv
`timescale 1ns/1ps
module test_boundary_tap;

  localparam int NP = 34;
  localparam int CL = 216;
  localparam int VW = 320;

  logic tck = 1'b0;
  logic por_n = 1'b0;
  logic tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en;
  logic [NP-1:0] core_out = '0, core_oe = '0, pin_in = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int vectors = 0;
  int miscompares = 0;
  logic en_seen;

  always #2.5 tck = ~tck;

  boundary_tap i_boundary_tap (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clk(input logic m, input logic d, output logic o);
    @(negedge tck);
    tms = m;
    tdi = d;
    #1;
    o = tdo;
  endtask

  task automatic settle();
    @(posedge tck);
    #1;
  endtask

  task automatic goto_reset_idle();
    logic o;
    for (int i = 0; i < 5; i++) clk(1'b1, 1'b0, o);
    clk(1'b0, 1'b0, o);
    settle();
  endtask

  task automatic shift_ir(input logic [7:0] op, output logic [7:0] cap);
    logic o;
    clk(1, 0, o); clk(1, 0, o); clk(0, 0, o); clk(0, 0, o);
    for (int i = 0; i < 8; i++) begin
      clk(i == 7, op[i], o);
      cap[i] = o;
    end
    clk(1, 0, o); clk(0, 0, o);
    settle();
  endtask

  task automatic shift_dr(input int n, input logic [VW-1:0] din, output logic [VW-1:0] dout);
    logic o;
    dout = '0;
    clk(1, 0, o); clk(0, 0, o); clk(0, 0, o);
    for (int i = 0; i < n; i++) begin
      clk(i == n - 1, din[i], o);
      dout[i] = o;
      if (i == 0) en_seen = tdo_en;
    end
    clk(1, 0, o); clk(0, 0, o);
    settle();
  endtask

  function automatic logic [VW-1:0] exp_cap(logic [NP-1:0] co, logic [NP-1:0] coe, logic [NP-1:0] pi);
    logic [VW-1:0] r = '0;
    for (int p = 0; p < NP; p++) begin
      r[3*p]   = coe[p];
      r[3*p+1] = co[p];
      r[3*p+2] = pi[p];
    end
    return r;
  endfunction

  function automatic logic [NP-1:0] fld(logic [VW-1:0] d, int ofs);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = d[3*p+ofs];
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_chain();
    logic [VW-1:0] r = '0;
    for (int i = 0; i < CL; i++) r[i] = 1'($urandom);
    return r;
  endfunction

  function automatic logic [NP-1:0] rand_np();
    return {2'($urandom), 32'($urandom)};
  endfunction

  logic [7:0]    cap8;
  logic [VW-1:0] dout, din, pre;
  logic [7:0]    op;
  bit done = 0;

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    core_out = rand_np(); core_oe = rand_np();
    repeat (3) @(negedge tck);
    // R9, R10: reset state of the outputs
    chk("R9 reset tdo_en", {319'd0, tdo_en}, '0);
    chk("R10 reset pads follow core", {pad_oe, pad_out}, {core_oe, core_out});
    por_n = 1'b1;
    tms = 1'b0;
    settle(); settle();

    // R1: identification word right after power-on
    shift_dr(32, '0, dout);
    chk("R1 ident after por", dout, 320'h29504093);
    chk("R9 tdo_en while shifting", {319'd0, en_seen}, 320'd1);
    chk("R9 tdo_en idle", {319'd0, tdo_en}, '0);

    // R3: capture pattern of the instruction register
    shift_ir(8'hFF, cap8);
    chk("R3 IR capture", {312'd0, cap8}, 320'h01);

    // R4: bypass, one bit capturing 0
    shift_dr(3, 320'b001, dout);
    chk("R4 bypass length", dout[2:0], 320'b010);

    // R2: reset from mid-shift restores ident
    begin
      logic o;
      clk(1, 0, o); clk(0, 0, o); clk(0, 0, o); clk(0, 1, o);
      goto_reset_idle();
    end
    shift_dr(32, '0, dout);
    chk("R2 five TMS high reaches reset (R1 ident)", dout, 320'h29504093);

    // R5: chain length measured with a marker bit
    shift_ir(8'h02, cap8);
    shift_dr(300, 320'd1, dout);
    chk("R5 marker at position 216", {319'd0, dout[216]}, 320'd1);
    chk("R5 nothing after marker", {237'd0, dout[299:217]}, '0);

    // Random sample/preload and external test
    for (int it = 0; it < 12; it++) begin
      core_out = rand_np(); core_oe = rand_np(); pin_in = rand_np();
      shift_ir(8'h02, cap8);
      pre = rand_chain();
      shift_dr(CL, pre, dout);
      chk("R6 sample capture", {104'd0, dout[CL-1:0]}, exp_cap(core_out, core_oe, pin_in));
      chk("R10 sample leaves pads on core", {pad_oe, pad_out}, {core_oe, core_out});
      shift_ir(8'h00, cap8);
      chk("R7 preload drives pads", {pad_oe, pad_out}, {fld(pre, 0), fld(pre, 1)});
      din = rand_chain();
      shift_dr(CL, din, dout);
      chk("R7 extest update drives pads", {pad_oe, pad_out}, {fld(din, 0), fld(din, 1)});
      // R4: random unassigned opcode acts as bypass
      do op = 8'($urandom); while (op == 8'h00 || op == 8'h01 || op == 8'h02 || op == 8'hFF);
      shift_ir(op, cap8);
      shift_dr(3, 320'b001, dout);
      chk("R4 unassigned opcode bypass", dout[2:0], 320'b010);
      chk("R10 pads on core under bypass", {pad_oe, pad_out}, {core_oe, core_out});
      // R8: scans under bypass leave the latches alone
      shift_ir(8'h00, cap8);
      chk("R8 latches kept across bypass scan", {pad_oe, pad_out}, {fld(din, 0), fld(din, 1)});
    end

    // R7: directed group codes, highest cell first: 111, 101, 100
    shift_ir(8'h00, cap8);
    din = '0;
    din[2:0] = 3'b111;
    din[5:3] = 3'b101;
    din[8:6] = 3'b100;
    shift_dr(CL, din, dout);
    chk("R7 group codes pad_out", {317'd0, pad_out[2:0]}, 320'b001);
    chk("R7 group codes pad_oe", {317'd0, pad_oe[2:0]}, 320'b011);

    // R8: reset clears the latches so external test releases every pad
    din = '0;
    for (int p = 0; p < NP; p++) din[3*p] = 1'b1;
    shift_dr(CL, din, dout);
    chk("R8 all enables set", {286'd0, pad_oe}, {286'd0, {NP{1'b1}}});
    goto_reset_idle();
    chk("R10 reset returns pads to core", {pad_oe, pad_out}, {core_oe, core_out});
    shift_ir(8'h00, cap8);
    chk("R8 enables cleared by reset", {286'd0, pad_oe}, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule